// File: doc/BRIEF.md
# Oversampling Pixel Averager

This datapath sits behind four parallel fast converters, each digitizing one detector output. A pixel begins when the pixel sync pulse arrives. The block then takes a programmable number of 14-bit samples from every channel and sums them in a wide accumulator. It divides the sum by the sample count with a right shift. The four averages are presented together on one wide output word, marked by a single valid strobe. Averaging several conversions of the same pixel improves the signal-to-noise ratio of the result.

The number of samples per pixel is 4, 8 or 16. It is chosen by a 2-bit code shifted in over a small serial control path and committed with a load strobe. The committed code is adopted only when a pixel starts. A pixel that is already being summed therefore always finishes with the count it began with. A sync pulse that arrives while a pixel is still being summed is rejected and counted in a saturating overrun counter.

Top module: `ovs_pixel_avg`

## Requirements
- R1: After reset, `res_valid` is 0, `res_data` is all zero, `ovr_cnt` is 0 and the committed factor is 4 samples per pixel.
- R2: On each cycle with `cfg_shift` high, `cfg_sdi` is shifted into a 2-bit code, most significant bit first. On a cycle with `cfg_load` high, the code is committed. The codes are: 00 means 4 samples, 01 means 8 and 10 means 16.
- R3: When a sync is accepted, the block takes exactly N sample strobes, where N is the committed factor. `res_valid` is high for exactly one cycle, the cycle after the Nth strobe is taken.
- R4: Channel c of `res_data` is bits [16c+15:16c]. It holds the sum of that channel's N samples divided by N and rounded down. Channel c of `smp_data` is bits [14c+13:14c].
- R5: All four channels update together under the one `res_valid` pulse. `res_data` holds its value between pulses.
- R6: Each cycle in which `sync` is high while a pixel is being summed is ignored, including the cycle of the last sample. Each such cycle adds one to `ovr_cnt`, which stops at 255.
- R7: A code committed while a pixel is being summed does not change that pixel's sample count. It takes effect at the next accepted sync.
- R8: Sample strobes while no pixel is active, and a strobe in the same cycle as the accepted sync, are ignored.
- R9: Bits [15:14] of every channel result are zero. Sixteen full-scale samples (3FFF hex) average to 3FFF hex with no overflow.
- R10: Committing the reserved code 11 leaves the committed factor unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Pixel start pulse |
| smp_stb | input | 1 | One sample per channel is present on `smp_data` |
| smp_data | input | 56 | Four 14-bit samples, channel c at bits [14c+13:14c] |
| cfg_shift | input | 1 | Shift `cfg_sdi` into the code register |
| cfg_sdi | input | 1 | Serial code bit |
| cfg_load | input | 1 | Commit the shifted code |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | 64 | Four 16-bit averages, channel c at bits [16c+15:16c] |
| ovr_cnt | output | 8 | Saturating count of rejected sync cycles |

## Verification
The bench sweeps every factor against constant, ramp, full-scale and scrambled samples, with and without idle gaps between strobes. An off-by-one sample counter would raise the strobe early or late, and a wrong shift would scale every average. The bench also moves the factor in the middle of a pixel, commits the reserved code, and drives strobes while idle and on the sync cycle. A design that switched the factor at once, accepted code 11 or summed stray samples would produce a wrong count or a wrong average. Sync is also driven during a pixel, on the last sample and for hundreds of cycles. A design that restarted the pixel, missed the last-cycle case or let the counter wrap would show a wrong average or a wrong `ovr_cnt`.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef enum logic [1:0] {
    OVS_X4   = 2'b00,
    OVS_X8   = 2'b01,
    OVS_X16  = 2'b10,
    OVS_RSVD = 2'b11
  } ovs_code_e;

  localparam int unsigned LOG_MAX = 4;

  function automatic logic [2:0] shift_of(input ovs_code_e code);
    case (code)
      OVS_X8:  return 3'd3;
      OVS_X16: return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [LOG_MAX-1:0] last_idx(input ovs_code_e code);
    case (code)
      OVS_X8:  return LOG_MAX'(7);
      OVS_X16: return LOG_MAX'(15);
      default: return LOG_MAX'(3);
    endcase
  endfunction
endpackage

// File: rtl/ovs_cfg.sv
module ovs_cfg
  import ovs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_shift,
  input  logic      cfg_sdi,
  input  logic      cfg_load,
  output ovs_code_e pend_code
);
  logic [1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= 2'b00;
      pend_code <= OVS_X4;
    end else begin
      if (cfg_shift) sr_q <= {sr_q[0], cfg_sdi};
      if (cfg_load && ovs_code_e'(sr_q) != OVS_RSVD) pend_code <= ovs_code_e'(sr_q);
    end
  end
endmodule

// File: rtl/ovs_seq.sv
module ovs_seq
  import ovs_pkg::*;
#(
  parameter int unsigned OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             smp_stb,
  input  ovs_code_e        pend_code,
  output logic             busy,
  output logic             start_evt,
  output logic             take_evt,
  output logic             last_evt,
  output logic             ovr_evt,
  output logic [2:0]       shift_act,
  output logic             res_valid,
  output logic [OVR_W-1:0] ovr_cnt
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  ovs_code_e          code_act;
  logic [LOG_MAX-1:0] cnt_q;

  assign start_evt = sync & ~busy;
  assign ovr_evt   = sync & busy;
  assign take_evt  = smp_stb & busy;
  assign last_evt  = take_evt && (cnt_q == last_idx(code_act));
  assign shift_act = shift_of(code_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      code_act  <= OVS_X4;
      res_valid <= 1'b0;
      ovr_cnt   <= '0;
    end else begin
      res_valid <= last_evt;
      if (start_evt) begin
        busy     <= 1'b1;
        cnt_q    <= '0;
        code_act <= pend_code;
      end else if (last_evt) begin
        busy <= 1'b0;
      end else if (take_evt) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ovr_evt && ovr_cnt != OVR_MAX) ovr_cnt <= ovr_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ovs_lane.sv
module ovs_lane #(
  parameter int unsigned SMP_W = 14,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             take_evt,
  input  logic             last_evt,
  input  logic [2:0]       shift_act,
  input  logic [SMP_W-1:0] sample,
  output logic [OUT_W-1:0] result
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] smp_ext;
  logic [ACC_W-1:0] sum_now;

  function automatic logic [OUT_W-1:0] avg_of(input logic [ACC_W-1:0] s,
                                               input logic [2:0] sh);
    logic [ACC_W-1:0] q;
    q = s >> sh;
    return q[OUT_W-1:0];
  endfunction

  assign smp_ext = ACC_W'(sample);
  assign sum_now = acc_q + smp_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      result <= '0;
    end else begin
      if (start_evt)     acc_q <= '0;
      else if (take_evt) acc_q <= sum_now;
      if (last_evt) result <= avg_of(sum_now, shift_act);
    end
  end
endmodule

// File: rtl/ovs_pixel_avg.sv
module ovs_pixel_avg
  import ovs_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SMP_W  = 14,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned OVR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync,
  input  logic                    smp_stb,
  input  logic [NUM_CH*SMP_W-1:0] smp_data,
  input  logic                    cfg_shift,
  input  logic                    cfg_sdi,
  input  logic                    cfg_load,
  output logic                    res_valid,
  output logic [NUM_CH*OUT_W-1:0] res_data,
  output logic [OVR_W-1:0]        ovr_cnt
);
  localparam int unsigned ACC_W = SMP_W + LOG_MAX;

  ovs_code_e  pend_code;
  logic       busy, start_evt, take_evt, last_evt, ovr_evt;
  logic [2:0] shift_act;

  ovs_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
    .cfg_load(cfg_load), .pend_code(pend_code)
  );

  ovs_seq #(.OVR_W(OVR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sync(sync), .smp_stb(smp_stb),
    .pend_code(pend_code), .busy(busy), .start_evt(start_evt),
    .take_evt(take_evt), .last_evt(last_evt), .ovr_evt(ovr_evt),
    .shift_act(shift_act), .res_valid(res_valid), .ovr_cnt(ovr_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    ovs_lane #(.SMP_W(SMP_W), .OUT_W(OUT_W), .ACC_W(ACC_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .take_evt(take_evt),
      .last_evt(last_evt), .shift_act(shift_act),
      .sample(smp_data[c*SMP_W +: SMP_W]),
      .result(res_data[c*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/ovs_pixel_avg_chk.sv
module ovs_pixel_avg_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SMP_W  = 14,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned OVR_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sync,
  input logic                    busy,
  input logic                    start_evt,
  input logic                    take_evt,
  input logic [2:0]              shift_act,
  input logic                    res_valid,
  input logic [NUM_CH*OUT_W-1:0] res_data,
  input logic [OVR_W-1:0]        ovr_cnt
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  function automatic logic [NUM_CH*OUT_W-1:0] hi_mask();
    logic [NUM_CH*OUT_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int b = SMP_W; b < OUT_W; b++) m[c*OUT_W + b] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_CH*OUT_W-1:0] HI_MASK = hi_mask();

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

  // R9
  high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_data & HI_MASK) == '0);

  // R6
  ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && busy) |=> ovr_cnt == (($past(ovr_cnt) == OVR_MAX) ? OVR_MAX : $past(ovr_cnt) + 1'b1));

  // R6
  ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync && busy) |=> $stable(ovr_cnt));

  // R7
  factor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_evt) |=> $stable(shift_act));

  // R8
  sync_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !take_evt);
endmodule

bind ovs_pixel_avg ovs_pixel_avg_chk #(
  .NUM_CH(NUM_CH), .SMP_W(SMP_W), .OUT_W(OUT_W), .OVR_W(OVR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .busy(busy), .start_evt(start_evt),
  .take_evt(take_evt), .shift_act(shift_act), .res_valid(res_valid),
  .res_data(res_data), .ovr_cnt(ovr_cnt)
);

// File: tb/ovs_pixel_avg_bench.sv
module ovs_pixel_avg_bench;
  localparam int NCH = 4;
  localparam int SW  = 14;
  localparam int OW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0, smp_stb = 1'b0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic cfg_shift = 1'b0, cfg_sdi = 1'b0, cfg_load = 1'b0;
  logic res_valid;
  logic [NCH*OW-1:0] res_data;
  logic [7:0] ovr_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ovs_pixel_avg u_ovs_pixel_avg (
    .clk(clk), .rst_n(rst_n), .sync(sync), .smp_stb(smp_stb),
    .smp_data(smp_data), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
    .cfg_load(cfg_load), .res_valid(res_valid), .res_data(res_data),
    .ovr_cnt(ovr_cnt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] smp(int pat, int pix, int c, int k);
    int unsigned h;
    case (pat)
      0: return SW'(c * 1000 + pix);
      1: return SW'((k * 517 + c * 91 + pix * 13) % 16384);
      2: return 14'h3FFF;
      default: begin
        h = 32'(pix) * 32'd1103515245 + 32'(k) * 32'd12345 + 32'(c) * 32'd2654435;
        return SW'(h >> 7);
      end
    endcase
  endfunction

  task automatic write_code(input logic [1:0] code);
    for (int i = 1; i >= 0; i--) begin
      cfg_sdi = code[i]; cfg_shift = 1'b1;
      @(negedge clk);
    end
    cfg_shift = 1'b0; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run_pixel(input int n, input int pat, input int pix,
                           input bit gaps, input bit stb_on_sync);
    longint sum [NCH];
    bit early = 1'b0;
    logic [NCH*OW-1:0] held;
    int lg;
    lg = (n == 4) ? 2 : (n == 8) ? 3 : 4;
    for (int c = 0; c < NCH; c++) sum[c] = 0;
    sync = 1'b1; smp_stb = stb_on_sync;
    smp_data = '1;
    @(negedge clk);
    sync = 1'b0; smp_stb = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (gaps && (k % 3 == 1)) begin
        @(negedge clk);
        if (res_valid) early = 1'b1;
      end
      for (int c = 0; c < NCH; c++) begin
        smp_data[c*SW +: SW] = smp(pat, pix, c, k);
        sum[c] += longint'(smp(pat, pix, c, k));
      end
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      if (k == n - 1) chk("R3 valid after last sample", res_valid, 1);
      else if (res_valid) early = 1'b1;
    end
    chk("R3 no early valid", early, 0);
    for (int c = 0; c < NCH; c++) begin
      chk(pat == 2 ? "R9 full scale average" : "R4 channel average",
          res_data[c*OW +: OW], sum[c] >> lg);
      chk("R9 high bits zero", res_data[c*OW + SW +: OW - SW], 0);
    end
    held = res_data;
    @(negedge clk);
    chk("R3 valid one cycle", res_valid, 0);
    chk("R5 data held", (res_data == held) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", res_valid, 0);
    chk("R1 reset data", (res_data == '0) ? 1 : 0, 1);
    chk("R1 reset overrun", ovr_cnt, 0);
    // R1: default factor is 4
    run_pixel(4, 1, 7, 1'b0, 1'b0);

    // R2 R4 R9: sweep of factors and sample patterns
    for (int code = 0; code < 3; code++) begin
      write_code(2'(code));
      for (int pat = 0; pat < 4; pat++)
        for (int pix = 0; pix < 4; pix++)
          run_pixel(4 << code, pat, pix, pix[0], 1'b0);
    end

    // R7: factor change part-way through a pixel
    write_code(2'b00);
    run_pixel(4, 3, 40, 1'b0, 1'b0);
    begin
      longint s [NCH];
      for (int c = 0; c < NCH; c++) s[c] = 0;
      sync = 1'b1; @(negedge clk); sync = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (k == 2) write_code(2'b10);
        for (int c = 0; c < NCH; c++) begin
          smp_data[c*SW +: SW] = smp(1, 9, c, k);
          s[c] += longint'(smp(1, 9, c, k));
        end
        smp_stb = 1'b1; @(negedge clk); smp_stb = 1'b0;
      end
      chk("R7 pixel ends at old count", res_valid, 1);
      for (int c = 0; c < NCH; c++)
        chk("R7 average with old factor", res_data[c*OW +: OW], s[c] >> 2);
      @(negedge clk);
    end
    run_pixel(16, 3, 41, 1'b1, 1'b0);  // R7: new factor at next sync

    // R10: reserved code keeps factor 16
    write_code(2'b11);
    run_pixel(16, 1, 42, 1'b0, 1'b0);

    // R8: idle strobes and a strobe on the sync cycle are ignored
    write_code(2'b01);
    smp_data = '1;
    smp_stb = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R8 idle strobe gives no valid", res_valid, 0);
    end
    smp_stb = 1'b0;
    run_pixel(8, 0, 43, 1'b0, 1'b1);

    // R6: sync during a pixel and on the last sample
    write_code(2'b00);
    begin
      longint s [NCH];
      for (int c = 0; c < NCH; c++) s[c] = 0;
      sync = 1'b1; @(negedge clk); sync = 1'b0;
      for (int k = 0; k < 4; k++) begin
        for (int c = 0; c < NCH; c++) begin
          smp_data[c*SW +: SW] = smp(3, 50, c, k);
          s[c] += longint'(smp(3, 50, c, k));
        end
        sync = (k == 1 || k == 3);
        smp_stb = 1'b1; @(negedge clk); smp_stb = 1'b0; sync = 1'b0;
      end
      chk("R6 pixel completes", res_valid, 1);
      chk("R6 overrun counted twice", ovr_cnt, 2);
      for (int c = 0; c < NCH; c++)
        chk("R6 sync ignored in average", res_data[c*OW +: OW], s[c] >> 2);
      @(negedge clk);
      chk("R6 no restart after last-cycle sync", res_valid, 0);
    end

    // R6: saturation
    sync = 1'b1; @(negedge clk);
    repeat (300) @(negedge clk);
    sync = 1'b0;
    chk("R6 overrun saturates", ovr_cnt, 255);
    smp_data = '0;
    for (int k = 0; k < 4; k++) begin
      smp_stb = 1'b1; @(negedge clk); smp_stb = 1'b0;
    end
    chk("R6 pixel still completes", res_valid, 1);
    chk("R6 zero average", (res_data == '0) ? 1 : 0, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule